// File: doc/BRIEF.md
# Segmented Memory Address Generator

This block turns a 16-bit segment base and a 16-bit offset into a 20-bit physical address. Each memory reference arrives with a reference kind. The kind picks a default segment register and an offset source. Some kinds also accept a segment-override request, and each of these kinds has its own set of permitted alternatives. Four segment registers (extra, code, stack, data) and four pointer registers (instruction pointer, stack pointer, source index, destination index) are held inside the block. Effective addresses for general variables and for base-pointer-relative references are computed outside and presented on `ea_i`.

The block also advances the string pointers. A per-pointer step strobe moves the source or destination index by one element on the next clock edge. A byte element moves it by 1 and a word element by 2, upward or downward. The address path is purely combinational from the current register contents, so a consumer sees the address in the same cycle that it presents the reference kind. A write port loads any of the eight registers.

Top module: `seg_addr_gen`

## Requirements
- R1: Reference kind 0 (instruction fetch) selects the code segment (segment code 1) with the instruction pointer as the offset, whatever the override inputs say.
- R2: Reference kind 1 (stack operation) selects the stack segment (segment code 2) with the stack pointer as the offset, whatever the override inputs say.
- R3: Reference kind 2 (general variable) and the unused kinds 6 and 7 select the data segment (code 3) with `ea_i` as the offset. When `ovr_req_i` is high, the segment named by `ovr_seg_i` is used instead (0 extra, 1 code, 2 stack, 3 data).
- R4: Reference kind 3 (string source) selects the data segment with the source index as the offset. An override request replaces the segment with `ovr_seg_i`.
- R5: Reference kind 5 (base-pointer base) selects the stack segment with `ea_i` as the offset. An override request replaces the segment with `ovr_seg_i`.
- R6: Reference kind 4 (string destination) selects the extra segment (code 0) with the destination index as the offset, whatever the override inputs say.
- R7: `bad_ovr_o` is high, in the same cycle, exactly when `ovr_req_i` is high with reference kind 0, 1 or 4. An override on those kinds changes neither the address nor the selected segment.
- R8: `phys_addr_o` equals the selected segment value times 16 plus the selected offset, modulo 2^20.
- R9: When `step_si_i` (or `step_di_i`) is high at a rising edge, the source (or destination) index changes by 1 if `word_i` is 0 and by 2 if it is 1. It decrements if `dec_i` is 1 and increments otherwise, wrapping modulo 2^16. Without its strobe, the index holds.
- R10: When `wr_en_i` is high at a rising edge, the register named by `wr_sel_i` is loaded with `wr_data_i`. The select codes are 0 extra, 1 code, 2 stack, 3 data, 4 instruction pointer, 5 stack pointer, 6 source index and 7 destination index. A write takes priority over a step of the same index register in that cycle.
- R11: While `rst_ni` is low, all eight registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write enable |
| wr_sel_i | input | 3 | Register select for writes |
| wr_data_i | input | 16 | Write data |
| ref_kind_i | input | 3 | Reference kind |
| ovr_req_i | input | 1 | Segment-override request |
| ovr_seg_i | input | 2 | Requested override segment |
| ea_i | input | 16 | Externally computed effective address |
| step_si_i | input | 1 | Step the source index |
| step_di_i | input | 1 | Step the destination index |
| word_i | input | 1 | Element size: 0 byte, 1 word |
| dec_i | input | 1 | Step direction: 0 up, 1 down |
| phys_addr_o | output | 20 | Physical address |
| seg_used_o | output | 2 | Segment actually selected |
| bad_ovr_o | output | 1 | Override requested on a kind that forbids it |

## Verification
Every reference kind is presented with override requests off and with each of the four override segments. Because all registers are loaded with distinct values, a wrong segment or offset source shows up as a distinct address. The index pointers are stepped in all four size/direction combinations, including steps across the 0xFFFF/0x0000 boundary, and a write is placed in the same cycle as a step to expose the priority. A segment and offset of all ones probe truncation at 20 bits. A random phase then mixes writes, steps and references so that any divergence is caught by the behavioural model.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
  typedef enum logic [2:0] {
    REF_FETCH = 3'd0,
    REF_STACK = 3'd1,
    REF_VAR   = 3'd2,
    REF_SRC   = 3'd3,
    REF_DST   = 3'd4,
    REF_BPB   = 3'd5
  } ref_kind_e;

  typedef enum logic [1:0] {
    SEG_ES = 2'd0,
    SEG_CS = 2'd1,
    SEG_SS = 2'd2,
    SEG_DS = 2'd3
  } seg_e;

  localparam int NUM_SEG = 4;
  localparam int NUM_PTR = 4;
  localparam int PTR_IP  = 0;
  localparam int PTR_SP  = 1;
  localparam int PTR_SI  = 2;
  localparam int PTR_DI  = 3;
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile #(
  parameter int W = 16,
  parameter int N = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N-1:0]        we_i,
  input  logic [W-1:0]        wdata_i,
  output logic [N-1:0][W-1:0] seg_q_o
);
  for (genvar i = 0; i < N; i++) begin : g_seg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      seg_q_o[i] <= '0;
      else if (we_i[i]) seg_q_o[i] <= wdata_i;
    end
  end
endmodule

// File: rtl/ptr_regs.sv
module ptr_regs
  import seg_addr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_PTR-1:0]        we_i,
  input  logic [W-1:0]              wdata_i,
  input  logic                      step_si_i,
  input  logic                      step_di_i,
  input  logic                      word_i,
  input  logic                      dec_i,
  output logic [NUM_PTR-1:0][W-1:0] ptr_q_o
);
  logic [W-1:0] delta;
  assign delta = word_i ? W'(2) : W'(1);

  for (genvar i = 0; i < NUM_PTR; i++) begin : g_ptr
    logic step;
    if (i == PTR_SI) begin : g_si
      assign step = step_si_i;
    end else if (i == PTR_DI) begin : g_di
      assign step = step_di_i;
    end else begin : g_fixed
      assign step = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      ptr_q_o[i] <= '0;
      else if (we_i[i]) ptr_q_o[i] <= wdata_i;  // write beats step
      else if (step)    ptr_q_o[i] <= dec_i ? ptr_q_o[i] - delta
                                            : ptr_q_o[i] + delta;
    end
  end
endmodule

// File: rtl/seg_select.sv
module seg_select
  import seg_addr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [2:0]   ref_kind_i,
  input  logic         ovr_req_i,
  input  logic [1:0]   ovr_seg_i,
  input  logic [W-1:0] ea_i,
  input  logic [W-1:0] ip_i,
  input  logic [W-1:0] sp_i,
  input  logic [W-1:0] si_i,
  input  logic [W-1:0] di_i,
  output seg_e         seg_o,
  output logic [W-1:0] ofs_o,
  output logic         bad_o
);
  logic ovr_ok;

  always_comb begin
    seg_o  = SEG_DS;
    ofs_o  = ea_i;
    bad_o  = 1'b0;
    ovr_ok = 1'b0;
    case (ref_kind_e'(ref_kind_i))
      REF_FETCH: begin seg_o = SEG_CS; ofs_o = ip_i; bad_o = ovr_req_i; end
      REF_STACK: begin seg_o = SEG_SS; ofs_o = sp_i; bad_o = ovr_req_i; end
      REF_DST:   begin seg_o = SEG_ES; ofs_o = di_i; bad_o = ovr_req_i; end
      REF_SRC:   begin seg_o = SEG_DS; ofs_o = si_i; ovr_ok = 1'b1; end
      REF_BPB:   begin seg_o = SEG_SS; ofs_o = ea_i; ovr_ok = 1'b1; end
      default:   begin seg_o = SEG_DS; ofs_o = ea_i; ovr_ok = 1'b1; end
    endcase
    if (ovr_ok && ovr_req_i) seg_o = seg_e'(ovr_seg_i);
  end
endmodule

// File: rtl/addr_adder.sv
module addr_adder #(
  parameter int SEG_W = 16,
  parameter int OFS_W = 16,
  parameter int SHIFT = 4,
  localparam int ADDR_W = SEG_W + SHIFT
) (
  input  logic [SEG_W-1:0]  seg_i,
  input  logic [OFS_W-1:0]  ofs_i,
  output logic [ADDR_W-1:0] addr_o
);
  assign addr_o = {seg_i, {SHIFT{1'b0}}} + ADDR_W'(ofs_i);
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_addr_pkg::*;
#(
  parameter int SEG_W = 16,
  parameter int OFS_W = 16,
  parameter int SHIFT = 4,
  localparam int ADDR_W = SEG_W + SHIFT,
  localparam int DATA_W = (SEG_W > OFS_W) ? SEG_W : OFS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [2:0]        ref_kind_i,
  input  logic              ovr_req_i,
  input  logic [1:0]        ovr_seg_i,
  input  logic [OFS_W-1:0]  ea_i,
  input  logic              step_si_i,
  input  logic              step_di_i,
  input  logic              word_i,
  input  logic              dec_i,
  output logic [ADDR_W-1:0] phys_addr_o,
  output logic [1:0]        seg_used_o,
  output logic              bad_ovr_o
);
  logic [NUM_SEG-1:0]             seg_we;
  logic [NUM_PTR-1:0]             ptr_we;
  logic [NUM_SEG-1:0][SEG_W-1:0]  seg_q;
  logic [NUM_PTR-1:0][OFS_W-1:0]  ptr_q;
  seg_e                           seg_sel;
  logic [OFS_W-1:0]               ofs_sel;

  // select codes: segments 0..3, pointers 4..7
  for (genvar i = 0; i < NUM_SEG; i++) begin : g_seg_we
    assign seg_we[i] = wr_en_i && (wr_sel_i == 3'(i));
  end
  for (genvar i = 0; i < NUM_PTR; i++) begin : g_ptr_we
    assign ptr_we[i] = wr_en_i && (wr_sel_i == 3'(i + NUM_SEG));
  end

  seg_regfile #(.W(SEG_W), .N(NUM_SEG)) u_segs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (seg_we),
    .wdata_i (wr_data_i[SEG_W-1:0]),
    .seg_q_o (seg_q)
  );

  ptr_regs #(.W(OFS_W)) u_ptrs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (ptr_we),
    .wdata_i   (wr_data_i[OFS_W-1:0]),
    .step_si_i (step_si_i),
    .step_di_i (step_di_i),
    .word_i    (word_i),
    .dec_i     (dec_i),
    .ptr_q_o   (ptr_q)
  );

  seg_select #(.W(OFS_W)) u_sel (
    .ref_kind_i (ref_kind_i),
    .ovr_req_i  (ovr_req_i),
    .ovr_seg_i  (ovr_seg_i),
    .ea_i       (ea_i),
    .ip_i       (ptr_q[PTR_IP]),
    .sp_i       (ptr_q[PTR_SP]),
    .si_i       (ptr_q[PTR_SI]),
    .di_i       (ptr_q[PTR_DI]),
    .seg_o      (seg_sel),
    .ofs_o      (ofs_sel),
    .bad_o      (bad_ovr_o)
  );

  addr_adder #(.SEG_W(SEG_W), .OFS_W(OFS_W), .SHIFT(SHIFT)) u_add (
    .seg_i  (seg_q[seg_sel]),
    .ofs_i  (ofs_sel),
    .addr_o (phys_addr_o)
  );

  assign seg_used_o = seg_sel;
endmodule

// File: rtl/seg_addr_gen_chk.sv
module seg_addr_gen_chk #(
  parameter int OFS_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [2:0]       wr_sel_i,
  input logic [2:0]       ref_kind_i,
  input logic             ovr_req_i,
  input logic             step_si_i,
  input logic             step_di_i,
  input logic             word_i,
  input logic             dec_i,
  input logic [1:0]       seg_used_o,
  input logic             bad_ovr_o,
  input logic [OFS_W-1:0] si_q,
  input logic [OFS_W-1:0] di_q
);
  logic [OFS_W-1:0] d;
  logic             si_wr, di_wr;
  assign d     = word_i ? OFS_W'(2) : OFS_W'(1);
  assign si_wr = wr_en_i && (wr_sel_i == 3'd6);
  assign di_wr = wr_en_i && (wr_sel_i == 3'd7);

  assert_fetch_cs_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_kind_i == 3'd0 |-> seg_used_o == 2'd1);

  assert_stack_ss_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_kind_i == 3'd1 |-> seg_used_o == 2'd2);

  assert_dst_es_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_kind_i == 3'd4 |-> seg_used_o == 2'd0);

  assert_bad_needs_req_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_ovr_o |-> ovr_req_i && (ref_kind_i == 3'd0 || ref_kind_i == 3'd1 || ref_kind_i == 3'd4));

  assert_si_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_si_i && !si_wr |=> si_q == $past(dec_i ? si_q - d : si_q + d));

  assert_di_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_di_i && !di_wr |=> di_q == $past(dec_i ? di_q - d : di_q + d));

  assert_si_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_si_i && !si_wr |=> $stable(si_q));

  assert_di_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_di_i && !di_wr |=> $stable(di_q));
endmodule

bind seg_addr_gen seg_addr_gen_chk #(.OFS_W(OFS_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .wr_sel_i   (wr_sel_i),
  .ref_kind_i (ref_kind_i),
  .ovr_req_i  (ovr_req_i),
  .step_si_i  (step_si_i),
  .step_di_i  (step_di_i),
  .word_i     (word_i),
  .dec_i      (dec_i),
  .seg_used_o (seg_used_o),
  .bad_ovr_o  (bad_ovr_o),
  .si_q       (ptr_q[2]),
  .di_q       (ptr_q[3])
);

// File: tb/seg_addr_gen_tb.sv
module seg_addr_gen_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  kind = '0;
  logic        ovr_req = 1'b0;
  logic [1:0]  ovr_seg = '0;
  logic [15:0] ea = '0;
  logic        step_si = 1'b0, step_di = 1'b0, word = 1'b0, dec = 1'b0;
  logic [19:0] addr;
  logic [1:0]  seg_used;
  logic        bad;

  int vectors = 0;
  int errors = 0;
  bit done = 0;

  // model: 0 ES,1 CS,2 SS,3 DS,4 IP,5 SP,6 SI,7 DI
  logic [15:0] m [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_addr_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .ref_kind_i(kind), .ovr_req_i(ovr_req),
    .ovr_seg_i(ovr_seg), .ea_i(ea), .step_si_i(step_si), .step_di_i(step_di),
    .word_i(word), .dec_i(dec), .phys_addr_o(addr), .seg_used_o(seg_used),
    .bad_ovr_o(bad)
  );

  function automatic string req_of(input logic [2:0] k, input logic o);
    if (o && (k == 0 || k == 1 || k == 4)) return "R7";
    case (k)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd3: return "R4";
      3'd4: return "R6";
      3'd5: return "R5";
      default: return "R3";
    endcase
  endfunction

  task automatic compare(input string tag);
    int s, o;
    logic b;
    logic [19:0] a;
    b = 1'b0;
    case (kind)
      3'd0: begin s = 1; o = m[4]; b = ovr_req; end
      3'd1: begin s = 2; o = m[5]; b = ovr_req; end
      3'd4: begin s = 0; o = m[7]; b = ovr_req; end
      3'd3: begin s = ovr_req ? ovr_seg : 3; o = m[6]; end
      3'd5: begin s = ovr_req ? ovr_seg : 2; o = ea; end
      default: begin s = ovr_req ? ovr_seg : 3; o = ea; end
    endcase
    a = 20'((m[s] * 16 + o) % (1 << 20));  // R8
    vectors++;
    if (addr !== a || seg_used !== 2'(s) || bad !== b) begin
      errors++;
      $display("FAIL %s/R8 kind=%0d: addr=%h seg=%0d bad=%b expected addr=%h seg=%0d bad=%b",
               tag, kind, addr, seg_used, bad, a, s, b);
    end
  endtask

  // drive after negedge, compare, then advance model for the coming posedge
  task automatic vec(input logic [2:0] k, input logic o, input logic [1:0] os,
                     input logic [15:0] e, input logic we, input logic [2:0] ws,
                     input logic [15:0] wd, input logic ssi, input logic sdi,
                     input logic w, input logic dn);
    @(negedge clk);
    kind = k; ovr_req = o; ovr_seg = os; ea = e; wr_en = we; wr_sel = ws;
    wr_data = wd; step_si = ssi; step_di = sdi; word = w; dec = dn;
    #1;
    compare(req_of(k, o));
    begin
      logic [15:0] st;
      st = w ? 16'd2 : 16'd1;
      if (ssi) m[6] = dn ? m[6] - st : m[6] + st;  // R9
      if (sdi) m[7] = dn ? m[7] - st : m[7] + st;
      if (we)  m[ws] = wd;                         // R10 write wins
    end
  endtask

  task automatic ld(input logic [2:0] s, input logic [15:0] d);
    vec(3'd2, 1'b0, 2'd0, 16'h0, 1'b1, s, d, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) m[i] = '0;
    // R11: registers zero during reset
    #(CLK_PERIOD * 2 + 2);
    for (int k = 0; k < 6; k++) begin
      kind = 3'(k); ea = 16'h0123; #1; compare("R11");
    end
    @(negedge clk); rst_n = 1'b1;

    // R10: load every register with a distinct value
    ld(0, 16'h1000); ld(1, 16'h2000); ld(2, 16'h3000); ld(3, 16'h4000);
    ld(4, 16'h0011); ld(5, 16'h0022); ld(6, 16'h0033); ld(7, 16'h0044);

    // R1 R2 R3 R4 R5 R6 R7: each kind, no override and all overrides
    for (int k = 0; k < 8; k++) begin
      vec(3'(k), 1'b0, 2'd0, 16'hABCD, 0, 0, 0, 0, 0, 0, 0);
      for (int s = 0; s < 4; s++)
        vec(3'(k), 1'b1, 2'(s), 16'h0F0F, 0, 0, 0, 0, 0, 0, 0);
    end

    // R9: byte/word, up/down, on both indices
    for (int c = 0; c < 4; c++) begin
      vec(3'd3, 0, 0, 0, 0, 0, 0, 1, 0, c[0], c[1]);
      vec(3'd4, 0, 0, 0, 0, 0, 0, 0, 1, c[0], c[1]);
      vec(3'd3, 0, 0, 0, 0, 0, 0, 1, 1, c[0], c[1]);
      vec(3'd4, 0, 0, 0, 0, 0, 0, 0, 0, c[0], c[1]);
    end
    // R9: wrap at top and bottom
    ld(6, 16'hFFFF); ld(7, 16'h0001);
    vec(3'd3, 0, 0, 0, 0, 0, 0, 1, 1, 1'b0, 1'b0);
    vec(3'd3, 0, 0, 0, 0, 0, 0, 0, 1, 1'b1, 1'b1);
    vec(3'd3, 0, 0, 0, 0, 0, 0, 1, 0, 1'b1, 1'b1);
    vec(3'd4, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    vec(3'd3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);

    // R10: write and step on same index in one cycle
    vec(3'd3, 0, 0, 0, 1, 3'd6, 16'h5555, 1, 1, 1, 0);
    vec(3'd3, 0, 0, 0, 1, 3'd7, 16'h7777, 1, 1, 0, 1);
    vec(3'd4, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    vec(3'd3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);

    // R8: truncation above 20 bits
    ld(3, 16'hFFFF);
    vec(3'd2, 0, 0, 16'hFFFF, 0, 0, 0, 0, 0, 0, 0);
    vec(3'd5, 1, 2'd3, 16'hFFFF, 0, 0, 0, 0, 0, 0, 0);

    // mixed random phase
    for (int i = 0; i < 600; i++) begin
      logic [31:0] r;
      r = $urandom;
      vec(3'(r[2:0]), r[3], r[5:4], 16'($urandom), r[6] & r[7], r[10:8],
          16'($urandom), r[11], r[12], r[13], r[14]);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule